// File: doc/BRIEF.md
# Reference-Windowed Clock Frequency Counter

This block estimates the frequency of one on-chip clock, chosen from a bank of up to sixteen clock inputs. It opens a window that lasts a programmed number of reference-crystal cycles and counts the edges of the chosen clock while the window is open. When the window closes, the final count is frozen in the measured clock's domain. A toggle handshake then carries it into the bus clock domain, where it becomes readable. Host software can turn the count into a frequency. With a 100 µs window, for example, the count times ten gives the frequency in kHz.

The block sits on a simple word-addressed register bus and has two registers. The control word is at byte offset 0. The read-only result is at byte offset 4. A typical host sequence is to save the control word, clear the result, program a window and a source, wait a little longer than the window, read the result, clear again, and write the saved control word back.

Top module: `clkmeter_top`

## Requirements
- R1: The control word at byte offset 0 holds these fields: window length in reference cycles at bits [15:0], load-enable at bit 16, run-enable at bit 20, clear at bit 24, and source code at bits [31:28]. A write with load-enable set reads back as exactly the written word ANDed with 0xF111FFFF. Writing a previously saved word back is therefore accepted unchanged.
- R2: Any write of the control word with the clear bit set makes the result register read zero from the next bus cycle on. The result keeps reading zero while the clear bit stays set. Any window in progress is abandoned and never reported.
- R3: A control write with load-enable=1, run-enable=1, clear=0 and a non-zero length starts a measurement. The result then equals, within ±2, the number of rising edges of the selected clock that fall within the length × reference-period window.
- R4: The result register changes only when a measurement completes, or through R2. It keeps its previous value while a window is running.
- R5: Source code k selects clock input k for k below the parameter NSRC. A code of NSRC or above selects no clock, and the result then stays at zero.
- R6: A control write with load-enable=0 leaves the length and source fields unchanged and starts no measurement. The run-enable, clear and load-enable bits still take the written values.
- R7: A start request with a length of zero starts no measurement, and a cleared result stays at zero.
- R8: Writes to byte offset 4 are ignored. Reads from any offset other than 0 or 4 return zero.
- R9: A control write with run-enable=0 and clear=0 stops a running window and cancels its report. The result keeps its previous value.
- R10: After reset, both registers read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for all three clock domains |
| bus_clk | input | 1 | Register bus clock |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge of bus_clk |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| ref_clk | input | 1 | Reference crystal clock that times the window |
| src_clk | input | NSRC | Clocks that can be measured, indexed by source code |

## Verification
Register effects are due one bus cycle after the write edge. The bench therefore drives each write on a falling edge and reads at the next falling edge: readback, the clear of the result, and ignored writes are all checked there. A measurement completes after several stages: two or three reference cycles of synchronization, the window of L reference cycles, up to three cycles of the measured clock, and three bus cycles. The bench waits (L+10)·4+20 bus cycles, which covers all of them even for the slowest source, before it compares the result with L·40 ns divided by that source's period, allowing ±2. Results that must not change are read both shortly after the stimulus and after a full measurement time.

// File: rtl/clkmeter_pkg.sv
package clkmeter_pkg;
   localparam int DATA_W   = 32;
   localparam int LEN_LSB  = 0;
   localparam int LEN_W    = 16;
   localparam int LOAD_BIT = 16;
   localparam int RUN_BIT  = 20;
   localparam int CLR_BIT  = 24;
   localparam int SEL_LSB  = 28;
   localparam int SEL_W    = 4;
   localparam int NCODE    = 1 << SEL_W;
   localparam logic [DATA_W-1:0] CTL_MASK = 32'hF111_FFFF;
   localparam int CTL_WORD = 0;
   localparam int RES_WORD = 1;
endpackage

// File: rtl/clkmeter_sync.sv
module clkmeter_sync #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
         q    <= '0;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/clkmeter_regs.sv
module clkmeter_regs
   import clkmeter_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              done_tgl,
   input  logic [CNT_W-1:0]  src_cnt,
   output logic [LEN_W-1:0]  len_q,
   output logic [SEL_W-1:0]  sel_q,
   output logic              run_req,
   output logic              start_tgl,
   output logic              pending,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [DATA_W-1:0] ctl_word
);
   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic              hit_ctl, hit_res;
   logic              load_q, run_q, clr_q;
   logic              done_s, done_d, done_edge;
   logic [LEN_W-1:0]  w_len;
   logic [SEL_W-1:0]  w_sel;
   logic              w_load, w_run, w_clr;
   logic              unused_bits;

   assign word    = bus_addr[ADDR_W-1:2];
   assign hit_ctl = (word == WORD_W'(CTL_WORD));
   assign hit_res = (word == WORD_W'(RES_WORD));

   assign w_len  = bus_wdata[LEN_LSB +: LEN_W];
   assign w_sel  = bus_wdata[SEL_LSB +: SEL_W];
   assign w_load = bus_wdata[LOAD_BIT];
   assign w_run  = bus_wdata[RUN_BIT];
   assign w_clr  = bus_wdata[CLR_BIT];
   assign unused_bits = ^{bus_wdata & ~CTL_MASK, bus_addr[1:0]};

   clkmeter_sync #(.W(1)) u_done_sync (
      .clk(clk), .rst_n(rst_n), .d(done_tgl), .q(done_s)
   );
   assign done_edge = done_s ^ done_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q     <= '0;
         sel_q     <= '0;
         load_q    <= 1'b0;
         run_q     <= 1'b0;
         clr_q     <= 1'b0;
         start_tgl <= 1'b0;
         pending   <= 1'b0;
         cnt_q     <= '0;
         done_d    <= 1'b0;
      end else begin
         done_d <= done_s;
         if (done_edge && pending) begin
            cnt_q   <= src_cnt;
            pending <= 1'b0;
         end
         if (bus_wr && hit_ctl) begin
            load_q <= w_load;
            run_q  <= w_run;
            clr_q  <= w_clr;
            if (w_load) begin
               len_q <= w_len;
               sel_q <= w_sel;
            end
            if (w_clr) begin
               cnt_q   <= '0;
               pending <= 1'b0;
            end else if (!w_run) begin
               pending <= 1'b0;
            end else if (w_load && (w_len != '0)) begin
               start_tgl <= ~start_tgl;
               pending   <= 1'b1;
            end
         end
      end
   end

   assign run_req = run_q & ~clr_q;

   always_comb begin
      ctl_word = '0;
      ctl_word[LEN_LSB +: LEN_W] = len_q;
      ctl_word[SEL_LSB +: SEL_W] = sel_q;
      ctl_word[LOAD_BIT]         = load_q;
      ctl_word[RUN_BIT]          = run_q;
      ctl_word[CLR_BIT]          = clr_q;
   end

   always_comb begin
      if (hit_ctl)      bus_rdata = ctl_word;
      else if (hit_res) bus_rdata = DATA_W'(cnt_q);
      else              bus_rdata = '0;
   end
endmodule

// File: rtl/clkmeter_window.sv
module clkmeter_window
   import clkmeter_pkg::*;
(
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic             run_req,
   input  logic             start_tgl,
   input  logic [LEN_W-1:0] win_len,
   output logic             win_act
);
   logic [1:0]       synced;
   logic             run_s, st_s, st_d;
   logic [LEN_W-1:0] elapsed;

   clkmeter_sync #(.W(2)) u_sync (
      .clk(ref_clk), .rst_n(rst_n), .d({run_req, start_tgl}), .q(synced)
   );
   assign run_s = synced[1];
   assign st_s  = synced[0];

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         st_d    <= 1'b0;
         win_act <= 1'b0;
         elapsed <= '0;
      end else begin
         st_d <= st_s;
         if (!run_s) begin
            win_act <= 1'b0;
            elapsed <= '0;
         end else if (st_s ^ st_d) begin
            win_act <= 1'b1;
            elapsed <= '0;
         end else if (win_act) begin
            if (elapsed == win_len - LEN_W'(1)) win_act <= 1'b0;
            elapsed <= elapsed + LEN_W'(1);
         end
      end
   end
endmodule

// File: rtl/clkmeter_edgecnt.sv
module clkmeter_edgecnt #(
   parameter int CNT_W = 32
) (
   input  logic             src_clk,
   input  logic             rst_n,
   input  logic             win_act,
   output logic [CNT_W-1:0] cnt,
   output logic             done_tgl
);
   logic act_s, act_d;

   clkmeter_sync #(.W(1)) u_sync (
      .clk(src_clk), .rst_n(rst_n), .d(win_act), .q(act_s)
   );

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) begin
         act_d    <= 1'b0;
         cnt      <= '0;
         done_tgl <= 1'b0;
      end else begin
         act_d <= act_s;
         if (act_s && !act_d)          cnt <= CNT_W'(1);
         else if (act_s && cnt != '1)  cnt <= cnt + CNT_W'(1);
         if (!act_s && act_d)          done_tgl <= ~done_tgl;
      end
   end
endmodule

// File: rtl/clkmeter_top.sv
module clkmeter_top
   import clkmeter_pkg::*;
#(
   parameter int NSRC   = 8,
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 8
) (
   input  logic              rst_n,
   input  logic              bus_clk,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ref_clk,
   input  logic [NSRC-1:0]   src_clk
);
   if (NSRC < 1 || NSRC > NCODE) begin : g_bad_nsrc
      $error("clkmeter_top: NSRC must lie in 1..%0d", NCODE);
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("clkmeter_top: CNT_W must lie in 1..%0d", DATA_W);
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("clkmeter_top: ADDR_W must be at least 3");
   end

   logic [LEN_W-1:0]  len_q;
   logic [SEL_W-1:0]  sel_q;
   logic              run_req, start_tgl, pending, win_act, done_tgl;
   logic [CNT_W-1:0]  src_cnt, cnt_q;
   logic [DATA_W-1:0] ctl_word;
   logic [NCODE-1:0]  clk_pad;
   logic              meas_clk;

   for (genvar i = 0; i < NCODE; i++) begin : g_pad
      if (i < NSRC) begin : g_live
         assign clk_pad[i] = src_clk[i];
      end else begin : g_tie
         assign clk_pad[i] = 1'b0;
      end
   end
   assign meas_clk = clk_pad[sel_q];

   clkmeter_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(bus_clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_tgl(done_tgl),
      .src_cnt(src_cnt), .len_q(len_q), .sel_q(sel_q), .run_req(run_req),
      .start_tgl(start_tgl), .pending(pending), .cnt_q(cnt_q),
      .ctl_word(ctl_word)
   );

   clkmeter_window u_win (
      .ref_clk(ref_clk), .rst_n(rst_n), .run_req(run_req),
      .start_tgl(start_tgl), .win_len(len_q), .win_act(win_act)
   );

   clkmeter_edgecnt #(.CNT_W(CNT_W)) u_cnt (
      .src_clk(meas_clk), .rst_n(rst_n), .win_act(win_act),
      .cnt(src_cnt), .done_tgl(done_tgl)
   );
endmodule

// File: rtl/clkmeter_chk.sv
module clkmeter_chk
   import clkmeter_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 8
) (
   input logic              bus_clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] ctl_word,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              pending,
   input logic              start_tgl
);
   logic wr_ctl, wr_res, unused_lo;
   assign wr_ctl    = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(CTL_WORD));
   assign wr_res    = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(RES_WORD));
   assign unused_lo = ^bus_addr[1:0];

   assert_readback_R1: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (wr_ctl && bus_wdata[LOAD_BIT]) |=> (ctl_word == ($past(bus_wdata) & CTL_MASK)));

   assert_clear_R2: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (wr_ctl && bus_wdata[CLR_BIT]) |=> (cnt_q == '0 && !pending));

   assert_hold_R4: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (!pending && !wr_ctl) |=> $stable(cnt_q));

   assert_noload_R6: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (wr_ctl && !bus_wdata[LOAD_BIT]) |=>
         ($stable(ctl_word[LEN_LSB +: LEN_W]) && $stable(ctl_word[SEL_LSB +: SEL_W])
          && $stable(start_tgl)));

   assert_zero_len_R7: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (wr_ctl && bus_wdata[LEN_LSB +: LEN_W] == '0) |=> $stable(start_tgl));

   assert_ro_result_R8: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (wr_res && !pending) |=> $stable(cnt_q));

   assert_stop_R9: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (wr_ctl && !bus_wdata[RUN_BIT]) |=> (!pending && $stable(start_tgl)));
endmodule

bind clkmeter_top clkmeter_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .bus_clk(bus_clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .ctl_word(ctl_word), .cnt_q(cnt_q),
   .pending(pending), .start_tgl(start_tgl)
);

// File: tb/tb_clkmeter_top.sv
`timescale 1ns/1ps
module tb_clkmeter_top;
   localparam int BUS_T  = 10;
   localparam int REF_T  = 40;
   localparam int NSRC   = 8;
   localparam int ADDR_W = 8;

   logic             rst_n = 1'b0;
   logic             bus_clk = 1'b0;
   logic             ref_clk = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic             bus_wr = 1'b0;
   logic [31:0]      bus_wdata = '0;
   logic [31:0]      bus_rdata;
   logic [NSRC-1:0]  src_clk = '0;

   int total = 0;
   int bad   = 0;

   function automatic int src_period(input int k);
      case (k)
         0: return 40;  1: return 12;  2: return 20;  3: return 16;
         4: return 10;  5: return 24;  6: return 32;  default: return 8;
      endcase
   endfunction

   function automatic logic [31:0] mkctl(input int len, input bit ld,
                                         input bit run, input bit clr, input int sel);
      return {sel[3:0], 3'b0, clr, 3'b0, run, 3'b0, ld, len[15:0]};
   endfunction

   function automatic bit in_tol(input int cnt, input int len, input int sel);
      int p, diff;
      p = src_period(sel);
      diff = cnt * p - len * REF_T;
      if (diff < 0) diff = -diff;
      return diff <= 2 * p;
   endfunction

   clkmeter_top #(.NSRC(NSRC), .CNT_W(32), .ADDR_W(ADDR_W)) dut (
      .rst_n(rst_n), .bus_clk(bus_clk), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_clk(ref_clk),
      .src_clk(src_clk)
   );

   always #(BUS_T/2) bus_clk = ~bus_clk;
   initial begin
      #3;
      forever #(REF_T/2) ref_clk = ~ref_clk;
   end
   for (genvar i = 0; i < NSRC; i++) begin : g_src
      initial begin
         #(1.3 + 0.7 * i);
         forever #(src_period(i) / 2.0) src_clk[i] = ~src_clk[i];
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input logic [31:0] data);
      @(negedge bus_clk);
      bus_addr  = ADDR_W'(addr);
      bus_wdata = data;
      bus_wr    = 1'b1;
      @(negedge bus_clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input int addr, output logic [31:0] data);
      @(negedge bus_clk);
      bus_addr = ADDR_W'(addr);
      #1;
      data = bus_rdata;
   endtask

   task automatic wait_meas(input int len);
      repeat ((len + 10) * 4 + 20) @(posedge bus_clk);
   endtask

   task automatic measure(input int len, input int sel, input string req);
      logic [31:0] v;
      wr(0, mkctl(0, 1, 0, 1, 0));
      rd(4, v);
      check(v == 0, "R2", v, 0);
      wr(0, mkctl(len, 1, 1, 0, sel));
      wait_meas(len);
      rd(4, v);
      check(in_tol(int'(v), len, sel), req, v, 32'(len * REF_T / src_period(sel)));
   endtask

   initial begin
      repeat (200000) @(posedge bus_clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v, saved;
      void'($urandom(32'd20240611));
      repeat (5) @(posedge bus_clk);
      rst_n = 1'b1;

      rd(0, v); check(v == 0, "R10 ctl", v, 0);
      rd(4, v); check(v == 0, "R10 result", v, 0);

      wr(0, 32'hFFFF_FFFF);
      rd(0, v); check(v == 32'hF111_FFFF, "R1 mask", v, 32'hF111_FFFF);

      measure(100, 7, "R3 code7");
      measure(60, 2, "R5 code2");
      measure(120, 0, "R5 code0");

      // R4: result holds previous value while a window runs
      wr(0, mkctl(0, 1, 0, 1, 0));
      wr(0, mkctl(150, 1, 1, 0, 4));
      repeat (40) @(posedge bus_clk);
      rd(4, v); check(v == 0, "R4 hold", v, 0);
      wait_meas(150);
      rd(4, v); check(in_tol(int'(v), 150, 4), "R4 update", v, 600);

      // R8: writes to result ignored, other offsets read zero
      saved = v;
      wr(4, 32'h1234_5678);
      rd(4, v); check(v == saved, "R8 ro", v, saved);
      rd(8, v); check(v == 0, "R8 unmapped", v, 0);

      // R2: abort mid-window, result stays zero
      wr(0, mkctl(200, 1, 1, 0, 2));
      repeat (100) @(posedge bus_clk);
      wr(0, mkctl(0, 0, 0, 1, 0));
      rd(4, v); check(v == 0, "R2 clear", v, 0);
      wait_meas(200);
      rd(4, v); check(v == 0, "R2 held", v, 0);

      // R9: run-enable off stops window, no report
      wr(0, mkctl(200, 1, 1, 0, 3));
      repeat (100) @(posedge bus_clk);
      wr(0, mkctl(0, 0, 0, 0, 0));
      wait_meas(200);
      rd(4, v); check(v == 0, "R9 stop", v, 0);
      rd(0, v); check(v == mkctl(200, 0, 0, 0, 3), "R9 ctl", v, mkctl(200, 0, 0, 0, 3));

      // R6: load-enable clear keeps length/source, no start
      wr(0, mkctl(77, 1, 0, 1, 5));
      wr(0, mkctl(55, 0, 1, 0, 3));
      rd(0, v); check(v == mkctl(77, 0, 1, 0, 5), "R6 fields", v, mkctl(77, 0, 1, 0, 5));
      wait_meas(77);
      rd(4, v); check(v == 0, "R6 nostart", v, 0);

      // R7: zero length
      wr(0, mkctl(0, 1, 0, 1, 0));
      wr(0, mkctl(0, 1, 1, 0, 7));
      wait_meas(50);
      rd(4, v); check(v == 0, "R7 zero", v, 0);

      // R5: unmapped source code
      wr(0, mkctl(0, 1, 0, 1, 0));
      wr(0, mkctl(50, 1, 1, 0, 9));
      wait_meas(50);
      rd(4, v); check(v == 0, "R5 unmapped", v, 0);

      // R1: save, clear, restore
      wr(0, mkctl(0, 1, 0, 1, 0));
      wr(0, mkctl(2700, 1, 1, 1, 6));
      rd(0, saved);
      wr(0, mkctl(0, 0, 0, 1, 0));
      wr(0, saved);
      rd(0, v); check(v == saved, "R1 restore", v, saved);

      for (int t = 0; t < 20; t++) begin
         int len, sel;
         len = int'($urandom_range(150, 1));
         sel = int'($urandom_range(7, 0));
         measure(len, sel, "R3 random");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule